// File: doc/BRIEF.md
# Paired-Stream Vector Summing Engine

This engine fetches two operand vectors from memory and leaves their element-wise sum in a local buffer. A single start pulse captures two base addresses, and the engine then asks for one incrementing read burst on each of its two independent AXI4 read-only master ports. Both address requests go out in the same cycle, so the two bursts overlap in time instead of running one after the other.

Returning data beats are matched by position. The engine accepts a beat only when both ports present one in the same cycle. It takes the pair on both ports together, adds the two words in one registered pipeline stage and writes the result into the buffer slot for that position. A port whose data arrives early simply waits with its ready signal low. When the final pair has been stored and the last-beat marker has been seen on both ports, the engine raises a one-cycle completion pulse. From then on the sums can be read from a combinational read-out port.

Top module: `vpa_top`

## Requirements
- R1: After reset, both ARVALID outputs, both RREADY outputs and `done` are low.
- R2: A start pulse while idle produces exactly one address handshake per port. ARVALID rises on both ports in the same cycle, with the address equal to that port's base, ARLEN = 49 (N-1), ARSIZE = 3'b010 (4-byte beats) and ARBURST = 2'b01 (incrementing).
- R3: Once ARVALID is high it stays high, with an unchanged address, until ARREADY is seen.
- R4: RREADY is high on a port only in a cycle where both ports present RVALID. The two ports therefore always have the same number of accepted beats, and a port that runs ahead is held.
- R5: After completion, buffer slot i holds (A[i] + B[i]) mod 2^32 for every i in 0..49, including sums that carry out of 32 bits.
- R6: With both streams valid on every cycle, one pair is consumed per cycle. `done` is high on the cycle N+2 clock edges after the edge that samples `start`.
- R7: `done` is a single-cycle pulse, issued exactly once per run, and only after all 50 beats, including the RLAST beat, have been accepted on both ports.
- R8: A start pulse while a run is in progress is ignored: no new address request goes out and the stored results come from the original bases.
- R9: A read-out index of 50 or above returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| base_a | input | 32 | Byte base address of operand A |
| base_b | input | 32 | Byte base address of operand B |
| done | output | 1 | One-cycle completion pulse |
| rd_idx | input | 6 | Buffer read-out index |
| rd_data | output | 32 | Buffer word at `rd_idx` (zero if out of range) |
| a_arvalid | output | 1 | Port A address valid |
| a_arready | input | 1 | Port A address ready |
| a_araddr | output | 32 | Port A burst address |
| a_arlen | output | 8 | Port A burst length minus one |
| a_arsize | output | 3 | Port A beat size code |
| a_arburst | output | 2 | Port A burst type |
| a_rvalid | input | 1 | Port A data valid |
| a_rready | output | 1 | Port A data ready |
| a_rdata | input | 32 | Port A data |
| a_rlast | input | 1 | Port A last beat |
| b_arvalid | output | 1 | Port B address valid |
| b_arready | input | 1 | Port B address ready |
| b_araddr | output | 32 | Port B burst address |
| b_arlen | output | 8 | Port B burst length minus one |
| b_arsize | output | 3 | Port B beat size code |
| b_arburst | output | 2 | Port B burst type |
| b_rvalid | input | 1 | Port B data valid |
| b_rready | output | 1 | Port B data ready |
| b_rdata | input | 32 | Port B data |
| b_rlast | input | 1 | Port B last beat |

## Verification
The hardest case to reach is one stream running several beats ahead of the other while the lagging stream arrives in bursts. In that case the engine must hold the leading port and still pair beats by position. The bench memory models give each port its own address-acceptance delay and a per-beat gap pattern that depends on the beat index. Across the sweep, each port in turn is left gap-free while the other stalls irregularly, which forces many cycles with only one side valid. Separate runs cover a gap-free stream for the exact one-pair-per-cycle latency, operands chosen so every sum carries out of 32 bits, and a second start pulse in the middle of a run.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
    localparam logic [1:0] BURST_INCR = 2'b01;

    typedef enum logic [0:0] {
        CTL_IDLE = 1'b0,
        CTL_BUSY = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/vpa_ar_issue.sv
module vpa_ar_issue #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } ar_st_t;

    ar_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.vld && arready) begin
            st_d.vld = 1'b0;
        end
        if (go) begin
            st_d.vld  = 1'b1;
            st_d.addr = base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign arvalid = st_q.vld;
    assign araddr  = st_q.addr;

    // R3: request held with a stable address until accepted
    p_ar_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && !arready) |=> (arvalid && $stable(araddr)));

    // R2: a single request per run; it drops right after its handshake
    p_ar_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && arready && !go) |=> !arvalid);
endmodule

// File: rtl/vpa_pair_join.sv
module vpa_pair_join #(
    parameter int DATA_W = 32,
    parameter int N      = 50,
    parameter int CNT_W  = 6,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic              a_rvalid,
    input  logic [DATA_W-1:0] a_rdata,
    input  logic              a_rlast,
    output logic              a_rready,
    input  logic              b_rvalid,
    input  logic [DATA_W-1:0] b_rdata,
    input  logic              b_rlast,
    output logic              b_rready,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              lasts_seen
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              wr_en;
        logic [IDX_W-1:0]  wr_idx;
        logic [DATA_W-1:0] wr_data;
        logic              seen_a;
        logic              seen_b;
    } pj_st_t;

    pj_st_t st_d, st_q;
    logic   room;
    logic   take;

    always_comb begin
        room  = enable && (st_q.cnt < CNT_W'(N));
        take  = room && a_rvalid && b_rvalid;
        st_d  = st_q;
        st_d.wr_en = take;
        if (take) begin
            st_d.wr_idx  = st_q.cnt[IDX_W-1:0];
            st_d.wr_data = a_rdata + b_rdata;
            st_d.cnt     = st_q.cnt + CNT_W'(1);
            st_d.seen_a  = st_q.seen_a | a_rlast;
            st_d.seen_b  = st_q.seen_b | b_rlast;
        end
        if (clear) begin
            st_d.cnt    = '0;
            st_d.wr_en  = 1'b0;
            st_d.seen_a = 1'b0;
            st_d.seen_b = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_rready   = take;
    assign b_rready   = take;
    assign wr_en      = st_q.wr_en;
    assign wr_idx     = st_q.wr_idx;
    assign wr_data    = st_q.wr_data;
    assign lasts_seen = st_q.seen_a && st_q.seen_b;

    // R4: the pair counter never passes the vector length
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(N));

    // R4: every stored sum follows a cycle where both ports handed over a beat
    p_wr_from_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(a_rvalid && b_rvalid && a_rready && b_rready));

    // R5: consecutive stores walk the buffer one slot at a time
    p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_idx == $past(wr_idx) + IDX_W'(1)));
endmodule

// File: rtl/vpa_sum_buf.sv
module vpa_sum_buf #(
    parameter int DATA_W = 32,
    parameter int N      = 50,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [N];
    logic              rd_in_range;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_in_range = (32'(rd_idx) < N);
        rd_data     = '0;
        if (rd_in_range) begin
            rd_data = mem_q[rd_idx];
        end
    end
endmodule

// File: rtl/vpa_top.sv
module vpa_top #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int N      = 50,
    localparam int IDX_W = $clog2(N),
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] base_b,
    output logic              done,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              a_arvalid,
    input  logic              a_arready,
    output logic [ADDR_W-1:0] a_araddr,
    output logic [7:0]        a_arlen,
    output logic [2:0]        a_arsize,
    output logic [1:0]        a_arburst,
    input  logic              a_rvalid,
    output logic              a_rready,
    input  logic [DATA_W-1:0] a_rdata,
    input  logic              a_rlast,
    output logic              b_arvalid,
    input  logic              b_arready,
    output logic [ADDR_W-1:0] b_araddr,
    output logic [7:0]        b_arlen,
    output logic [2:0]        b_arsize,
    output logic [1:0]        b_arburst,
    input  logic              b_rvalid,
    output logic              b_rready,
    input  logic [DATA_W-1:0] b_rdata,
    input  logic              b_rlast
);
    import vpa_pkg::*;

    localparam int           NPORT     = 2;
    localparam logic [7:0]   LEN_CODE  = 8'(N - 1);
    localparam logic [2:0]   SIZE_CODE = 3'($clog2(DATA_W / 8));

    typedef struct packed {
        ctl_state_e state;
        logic       done;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic                   go;
    logic                   busy;
    logic [NPORT-1:0]       arvalid_w;
    logic [NPORT-1:0]       arready_w;
    logic [ADDR_W-1:0]      base_w  [NPORT];
    logic [ADDR_W-1:0]      araddr_w[NPORT];
    logic                   wr_en;
    logic [IDX_W-1:0]       wr_idx;
    logic [DATA_W-1:0]      wr_data;
    logic                   lasts_seen;

    assign busy = (ctl_q.state == CTL_BUSY);
    assign go   = start && !busy;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (go) begin
            ctl_d.state = CTL_BUSY;
        end else if (busy && wr_en && (wr_idx == IDX_W'(N - 1)) && lasts_seen) begin
            ctl_d.state = CTL_IDLE;
            ctl_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: CTL_IDLE, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done = ctl_q.done;

    assign base_w[0]    = base_a;
    assign base_w[1]    = base_b;
    assign arready_w[0] = a_arready;
    assign arready_w[1] = b_arready;

    for (genvar p = 0; p < NPORT; p++) begin : g_ar
        vpa_ar_issue #(.ADDR_W(ADDR_W)) u_ar (
            .clk     (clk),
            .rst_n   (rst_n),
            .go      (go),
            .base    (base_w[p]),
            .arvalid (arvalid_w[p]),
            .arready (arready_w[p]),
            .araddr  (araddr_w[p])
        );
    end

    assign a_arvalid = arvalid_w[0];
    assign a_araddr  = araddr_w[0];
    assign b_arvalid = arvalid_w[1];
    assign b_araddr  = araddr_w[1];
    assign a_arlen   = LEN_CODE;
    assign b_arlen   = LEN_CODE;
    assign a_arsize  = SIZE_CODE;
    assign b_arsize  = SIZE_CODE;
    assign a_arburst = BURST_INCR;
    assign b_arburst = BURST_INCR;

    vpa_pair_join #(
        .DATA_W (DATA_W),
        .N      (N),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) u_join (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (go),
        .enable     (busy),
        .a_rvalid   (a_rvalid),
        .a_rdata    (a_rdata),
        .a_rlast    (a_rlast),
        .a_rready   (a_rready),
        .b_rvalid   (b_rvalid),
        .b_rdata    (b_rdata),
        .b_rlast    (b_rlast),
        .b_rready   (b_rready),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .lasts_seen (lasts_seen)
    );

    vpa_sum_buf #(
        .DATA_W (DATA_W),
        .N      (N),
        .IDX_W  (IDX_W)
    ) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // R7: completion lasts exactly one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: completion only directly after the final store
    p_done_after_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_en));

    // R2: both address requests start together
    p_ar_together_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_arvalid) |-> $rose(b_arvalid));

    // R8: a start during a run raises no new request
    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (!$rose(a_arvalid) && !$rose(b_arvalid)));
endmodule

// File: tb/vpa_top_test.sv
module vpa_top_test;
    localparam int N = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_a = '0;
    logic [31:0] base_b = '0;
    logic        done;
    logic [5:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        a_arvalid, b_arvalid;
    logic [31:0] a_araddr, b_araddr;
    logic [7:0]  a_arlen, b_arlen;
    logic [2:0]  a_arsize, b_arsize;
    logic [1:0]  a_arburst, b_arburst;
    logic        a_rready, b_rready;

    logic [1:0]  s_arready = '0;
    logic [1:0]  s_rvalid  = '0;
    logic [1:0]  s_rlast   = '0;
    logic [31:0] s_rdata [2];

    always #5 clk = ~clk;

    vpa_top uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_a(base_a), .base_b(base_b),
        .done(done), .rd_idx(rd_idx), .rd_data(rd_data),
        .a_arvalid(a_arvalid), .a_arready(s_arready[0]), .a_araddr(a_araddr),
        .a_arlen(a_arlen), .a_arsize(a_arsize), .a_arburst(a_arburst),
        .a_rvalid(s_rvalid[0]), .a_rready(a_rready), .a_rdata(s_rdata[0]), .a_rlast(s_rlast[0]),
        .b_arvalid(b_arvalid), .b_arready(s_arready[1]), .b_araddr(b_araddr),
        .b_arlen(b_arlen), .b_arsize(b_arsize), .b_arburst(b_arburst),
        .b_rvalid(s_rvalid[1]), .b_rready(b_rready), .b_rdata(s_rdata[1]), .b_rlast(s_rlast[1])
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cfg_cur = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] val_of(int p, int i, int cfg);
        if (cfg == 7) return (p == 0) ? (32'hFFFF_FFFF - 32'(i)) : (32'h1 + 32'(2 * i));
        return 32'(cfg + 1) * 32'h0101_0101 * 32'(p + 1) + 32'(i) * (32'h1000_0003 + 32'(p * 7));
    endfunction

    function automatic int gap_of(int p, int i, int cfg);
        case (cfg)
            1: return (p == 1) ? (i % 3) : (i % 2);
            2: return (p == 1) ? ((i % 4 == 0) ? 3 : 0) : (i % 5);
            3: return (i + p) % 3;
            4: return (p == 1) ? (i % 7) : 0;
            5: return (p == 1) ? 0 : ((i * 3) % 7);
            6: return (p == 1) ? (((i / 8) % 2) * 4) : (((i / 5) % 2) * 2);
            default: return 0;
        endcase
    endfunction

    function automatic int lat_of(int p, int cfg);
        if (cfg == 0 || cfg == 7) return 0;
        return (cfg + p * 2) % 4;
    endfunction

    // memory models
    logic [1:0] hs_ar = '0;
    logic [1:0] hs_r  = '0;
    logic       slv_clear = 1'b0;
    int got_ar[2], ar_wait[2], beat[2], gap_cnt[2];

    always @(negedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (slv_clear) begin
                got_ar[p] = 0; ar_wait[p] = 0; beat[p] = 0; gap_cnt[p] = 0;
                s_arready[p] = 1'b0; s_rvalid[p] = 1'b0; s_rlast[p] = 1'b0; s_rdata[p] = '0;
            end else begin
                if (hs_ar[p]) begin
                    got_ar[p] = 1;
                    s_arready[p] = 1'b0;
                end else if (((p == 0) ? a_arvalid : b_arvalid) && got_ar[p] == 0) begin
                    if (ar_wait[p] >= lat_of(p, cfg_cur)) s_arready[p] = 1'b1;
                    else ar_wait[p]++;
                end
                if (hs_r[p]) begin
                    beat[p]++;
                    s_rvalid[p] = 1'b0;
                    s_rlast[p] = 1'b0;
                    gap_cnt[p] = 0;
                end
                if (got_ar[p] != 0 && !s_rvalid[p] && beat[p] < N) begin
                    if (gap_cnt[p] >= gap_of(p, beat[p], cfg_cur)) begin
                        s_rvalid[p] = 1'b1;
                        s_rdata[p]  = val_of(p, beat[p], cfg_cur);
                        s_rlast[p]  = (beat[p] == N - 1);
                    end else begin
                        gap_cnt[p]++;
                    end
                end
            end
        end
    end

    // monitor
    int cyc = 0;
    bit mon_on = 0;
    int ar_cnt[2], acc[2], rise_cyc[2];
    logic [31:0] cap_addr[2];
    logic [7:0]  cap_len[2];
    logic [2:0]  cap_size[2];
    logic [1:0]  cap_burst[2];
    int hold_viol, pair_viol, done_cnt, done_early, start_cyc, done_cyc;
    bit          prev_wait[2];
    logic [31:0] prev_addr[2];

    always @(posedge clk) begin
        logic [1:0] arv, rdy;
        logic [31:0] ad [2];
        arv = {b_arvalid, a_arvalid};
        rdy = {b_rready, a_rready};
        ad[0] = a_araddr;
        ad[1] = b_araddr;
        hs_ar <= arv & s_arready;
        hs_r  <= rdy & s_rvalid;
        cyc++;
        if (rst_n && mon_on) begin
            for (int p = 0; p < 2; p++) begin
                if (prev_wait[p] && !(arv[p] && ad[p] == prev_addr[p])) hold_viol++;
                prev_wait[p] = arv[p] && !s_arready[p];
                prev_addr[p] = ad[p];
                if (arv[p] && rise_cyc[p] < 0) rise_cyc[p] = cyc;
                if (arv[p] && s_arready[p]) begin
                    ar_cnt[p]++;
                    cap_addr[p]  = ad[p];
                    cap_len[p]   = (p == 0) ? a_arlen : b_arlen;
                    cap_size[p]  = (p == 0) ? a_arsize : b_arsize;
                    cap_burst[p] = (p == 0) ? a_arburst : b_arburst;
                end
                if (rdy[p] && !(s_rvalid[0] && s_rvalid[1])) pair_viol++;
                if (rdy[p] && s_rvalid[p]) acc[p]++;
            end
            if (acc[0] != acc[1]) pair_viol++;
            if (start && start_cyc < 0) start_cyc = cyc;
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
                if (acc[0] != N || acc[1] != N) done_early++;
            end
        end
    end

    task automatic run_cfg(input int cfg);
        int t;
        logic [31:0] ba, bb, exp;
        string tag;
        tag = $sformatf("cfg%0d", cfg);
        cfg_cur = cfg;
        @(negedge clk);
        slv_clear = 1'b1;
        @(negedge clk);
        #1 slv_clear = 1'b0;
        for (int p = 0; p < 2; p++) begin
            ar_cnt[p] = 0; acc[p] = 0; rise_cyc[p] = -1; prev_wait[p] = 0;
        end
        hold_viol = 0; pair_viol = 0; done_cnt = 0; done_early = 0;
        start_cyc = -1; done_cyc = -1;
        mon_on = 1;
        ba = 32'h1000_0000 + 32'(cfg) * 32'h400;
        bb = 32'h8000_0000 + 32'(cfg) * 32'h800;
        @(negedge clk);
        base_a = ba; base_b = bb; start = 1'b1;
        @(negedge clk);
        start = 1'b0; base_a = 32'hDEAD_0000; base_b = 32'hBEEF_0000;
        if (cfg == 3) begin
            repeat (10) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (done_cnt == 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
        mon_on = 0;

        for (int p = 0; p < 2; p++) begin
            check(ar_cnt[p] == 1, "R2", {tag, " address handshakes"}, ar_cnt[p], 1);
            check(cap_addr[p] == ((p == 0) ? ba : bb), (cfg == 3) ? "R8" : "R2",
                  {tag, " burst address"}, cap_addr[p], (p == 0) ? ba : bb);
            check(cap_len[p] == 8'd49 && cap_size[p] == 3'b010 && cap_burst[p] == 2'b01, "R2",
                  {tag, " len/size/burst"}, {cap_len[p], cap_size[p], cap_burst[p]},
                  {8'd49, 3'b010, 2'b01});
        end
        check(rise_cyc[0] == rise_cyc[1], "R2", {tag, " concurrent request cycle"},
              rise_cyc[0], rise_cyc[1]);
        check(hold_viol == 0, "R3", {tag, " request hold"}, hold_viol, 0);
        check(pair_viol == 0, "R4", {tag, " lockstep acceptance"}, pair_viol, 0);
        check(done_cnt == 1, "R7", {tag, " done pulses"}, done_cnt, 1);
        check(done_early == 0, "R7", {tag, " done before all beats"}, done_early, 0);
        if (cfg == 0)
            check(done_cyc - start_cyc == N + 3, "R6", {tag, " gap-free latency"},
                  done_cyc - start_cyc, N + 3);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            rd_idx = 6'(i);
            #1;
            exp = val_of(0, i, cfg) + val_of(1, i, cfg);
            check(rd_data == exp, (cfg == 3) ? "R8" : "R5", $sformatf("%s sum[%0d]", tag, i),
                  rd_data, exp);
            if (cfg == 7)
                check(rd_data == 32'(i), "R5", $sformatf("wrapped sum[%0d]", i), rd_data, i);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!a_arvalid && !b_arvalid, "R1", "arvalid in reset", {a_arvalid, b_arvalid}, 0);
        check(!a_rready && !b_rready && !done, "R1", "rready/done in reset",
              {a_rready, b_rready, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!a_arvalid && !b_arvalid && !done, "R1", "idle after reset",
              {a_arvalid, b_arvalid, done}, 0);
        for (int c = 0; c < 8; c++) run_cfg(c);
        for (int i = N; i < 64; i++) begin
            @(negedge clk);
            rd_idx = 6'(i);
            #1;
            check(rd_data == 32'h0, "R9", $sformatf("out-of-range read %0d", i), rd_data, 0);
        end
        finish_run();
    end
endmodule